// File: doc/BRIEF.md
# Packed Halfword Saturating Arithmetic Unit

This block is a 64-bit SIMD datapath that splits each of its two operands into four 16-bit lanes and applies one lane-wise operation to all of them at once. A 3-bit opcode chooses the operation. The choices are:

- add or subtract with signed clamping;
- add or subtract with unsigned clamping, where the first operand is read as unsigned and the second as signed;
- an unsigned average that folds the discarded bit back into the result;
- scale-then-add forms that shift the first lane left or arithmetically right by a 2-bit amount, add the second lane, and clamp as signed.

No carry or borrow crosses a lane boundary.

The arithmetic is purely combinational. An output register, present by default, makes the packed result appear one clock after the operands. With the register removed, the result follows the inputs directly. Operand storage, instruction decode and pipeline control sit outside the block.

Top module: `psat_simd_unit`

## Requirements
- R1: Lane k occupies bits [16k+15:16k] of both operands and the result, for k = 0 to 3. Each result lane depends only on the same lane of the operands, on the opcode and on the shift amount, so no carry or borrow crosses a lane boundary.
- R2: Opcode 0 (signed add) and opcode 1 (signed subtract, first minus second) sign-extend both lanes. They clamp the result to the range -32768 to 32767, which is 0x8000 to 0x7FFF.
- R3: Opcode 2 (add) and opcode 3 (subtract, first minus second) read the first lane as unsigned (0 to 65535) and the second lane as signed. They clamp the result to the range 0x0000 to 0xFFFF.
- R4: Opcode 4 forms the unsigned 17-bit sum s of the two lanes. It returns (s >> 1) | (s & 1), so the result's least significant bit is the OR of s[1] and s[0].
- R5: Opcode 5 shifts the signed first lane left by the shift amount, adds the signed second lane and clamps as in R2. No bits are lost before the clamp.
- R6: Opcode 6 arithmetically shifts the signed first lane right by the shift amount, which rounds toward minus infinity. It then adds the signed second lane and clamps as in R2.
- R7: The shift amount is a 2-bit value from 0 to 3. It has no effect on opcodes 0 to 4.
- R8: Opcode 7 is unused and produces an all-zero result.
- R9: With the output register enabled, the result for operands applied before a rising clock edge appears after that edge. An active-low asynchronous reset clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_i | input | 3 | Operation select (0 to 7, see R2 to R8) |
| shamt_i | input | 2 | Shift amount for opcodes 5 and 6 |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| result_o | output | 64 | Packed result |

## Verification
The directed vectors place a different case in each lane of one word, so a single comparison can tell correct clamping from carry leakage into a neighbour. Examples are positive overflow next to negative overflow, and an in-range sum next to a zero lane. The unsigned-clamp vectors pair a large unsigned first lane with a negative second lane, which exposes a design that treats both operands alike. The average vectors use odd and even sums to separate OR-rounding from add-rounding. The scale vectors use shift amounts 2 and 3 with operands whose shifted value only fits because of the widened intermediate. Repeating a signed add under a non-zero shift amount, followed by a random sweep over all opcodes, confirms that the shift amount is ignored outside the scale forms.

// File: rtl/psat_pkg.sv
package psat_pkg;

  localparam int unsigned LANE_W_DEF  = 16;
  localparam int unsigned LANES_DEF   = 4;
  localparam int unsigned SHAMT_W_DEF = 2;
  localparam int unsigned OP_W        = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_SS = 3'd0,
    OP_SUB_SS = 3'd1,
    OP_ADD_US = 3'd2,
    OP_SUB_US = 3'd3,
    OP_AVG    = 3'd4,
    OP_SHLADD = 3'd5,
    OP_SHRADD = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_SGN  = 2'd1,
    CLAMP_UNS  = 2'd2
  } clamp_e;

endpackage

// File: rtl/psat_lane_core.sv
module psat_lane_core
  import psat_pkg::*;
#(
  parameter int unsigned LANE_W  = LANE_W_DEF,
  parameter int unsigned SHAMT_W = SHAMT_W_DEF,
  parameter int unsigned WIDE_W  = LANE_W + (1 << SHAMT_W)
) (
  input  logic [OP_W-1:0]           op_i,
  input  logic [SHAMT_W-1:0]        shamt_i,
  input  logic [LANE_W-1:0]         a_i,
  input  logic [LANE_W-1:0]         b_i,
  output logic signed [WIDE_W-1:0]  wide_o,
  output clamp_e                    mode_o
);

  localparam int unsigned EXT_W = WIDE_W - LANE_W;

  function automatic logic signed [WIDE_W-1:0] f_sext(input logic [LANE_W-1:0] x);
    return $signed({{EXT_W{x[LANE_W-1]}}, x});
  endfunction

  function automatic logic signed [WIDE_W-1:0] f_zext(input logic [LANE_W-1:0] x);
    return $signed({{EXT_W{1'b0}}, x});
  endfunction

  // Halve a non-negative sum, folding the dropped bit back in by OR.
  function automatic logic signed [WIDE_W-1:0] f_avg(input logic signed [WIDE_W-1:0] s);
    logic signed [WIDE_W-1:0] h;
    h = s >>> 1;
    h[0] = h[0] | s[0];
    return h;
  endfunction

  function automatic logic signed [WIDE_W-1:0] f_shl_add(
    input logic signed [WIDE_W-1:0] a, input logic signed [WIDE_W-1:0] b,
    input logic [SHAMT_W-1:0] sh);
    return (a <<< sh) + b;
  endfunction

  function automatic logic signed [WIDE_W-1:0] f_shr_add(
    input logic signed [WIDE_W-1:0] a, input logic signed [WIDE_W-1:0] b,
    input logic [SHAMT_W-1:0] sh);
    return (a >>> sh) + b;
  endfunction

  logic signed [WIDE_W-1:0] sa, sb, ua, ub;

  assign sa = f_sext(a_i);
  assign sb = f_sext(b_i);
  assign ua = f_zext(a_i);
  assign ub = f_zext(b_i);

  always_comb begin
    wide_o = '0;
    mode_o = CLAMP_NONE;
    case (op_e'(op_i))
      OP_ADD_SS: begin wide_o = sa + sb;                      mode_o = CLAMP_SGN; end
      OP_SUB_SS: begin wide_o = sa - sb;                      mode_o = CLAMP_SGN; end
      OP_ADD_US: begin wide_o = ua + sb;                      mode_o = CLAMP_UNS; end
      OP_SUB_US: begin wide_o = ua - sb;                      mode_o = CLAMP_UNS; end
      OP_AVG:    begin wide_o = f_avg(ua + ub);               mode_o = CLAMP_NONE; end
      OP_SHLADD: begin wide_o = f_shl_add(sa, sb, shamt_i);   mode_o = CLAMP_SGN; end
      OP_SHRADD: begin wide_o = f_shr_add(sa, sb, shamt_i);   mode_o = CLAMP_SGN; end
      default:   begin wide_o = '0;                           mode_o = CLAMP_NONE; end
    endcase
  end

endmodule

// File: rtl/psat_lane_clamp.sv
module psat_lane_clamp
  import psat_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned WIDE_W = LANE_W + 4
) (
  input  logic signed [WIDE_W-1:0] wide_i,
  input  clamp_e                   mode_i,
  output logic [LANE_W-1:0]        lane_o
);

  localparam logic signed [WIDE_W-1:0] S_MAX = WIDE_W'((64'sd1 <<< (LANE_W-1)) - 64'sd1);
  localparam logic signed [WIDE_W-1:0] S_MIN = -S_MAX - WIDE_W'(1);
  localparam logic signed [WIDE_W-1:0] U_MAX = WIDE_W'((64'sd1 <<< LANE_W) - 64'sd1);
  localparam logic [LANE_W-1:0] L_SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] L_SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic over_s, under_s, over_u, under_u;

  assign over_s  = wide_i > S_MAX;
  assign under_s = wide_i < S_MIN;
  assign over_u  = wide_i > U_MAX;
  assign under_u = wide_i[WIDE_W-1];

  always_comb begin
    lane_o = wide_i[LANE_W-1:0];
    case (mode_i)
      CLAMP_SGN: begin
        if (over_s)       lane_o = L_SMAX;
        else if (under_s) lane_o = L_SMIN;
      end
      CLAMP_UNS: begin
        if (under_u)      lane_o = '0;
        else if (over_u)  lane_o = '1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/psat_out_stage.sv
module psat_out_stage #(
  parameter int unsigned W          = 64,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
      end
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/psat_simd_unit.sv
module psat_simd_unit
  import psat_pkg::*;
#(
  parameter int unsigned LANE_W  = LANE_W_DEF,
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned SHAMT_W = SHAMT_W_DEF,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op_i,
  input  logic [SHAMT_W-1:0]        shamt_i,
  input  logic [LANE_W*LANES-1:0]   a_i,
  input  logic [LANE_W*LANES-1:0]   b_i,
  output logic [LANE_W*LANES-1:0]   result_o
);

  localparam int unsigned DATA_W = LANE_W * LANES;
  localparam int unsigned WIDE_W = LANE_W + (1 << SHAMT_W);
  localparam logic signed [WIDE_W-1:0] S_MAX = WIDE_W'((64'sd1 <<< (LANE_W-1)) - 64'sd1);
  localparam logic signed [WIDE_W-1:0] S_MIN = -S_MAX - WIDE_W'(1);
  localparam logic signed [WIDE_W-1:0] U_MAX = WIDE_W'((64'sd1 <<< LANE_W) - 64'sd1);

  logic signed [WIDE_W-1:0] lane_wide [LANES];
  clamp_e                   lane_mode [LANES];
  logic [LANE_W-1:0]        lane_val  [LANES];
  logic [DATA_W-1:0]        comb_res;

  logic sgn_op, uns_op;
  assign sgn_op = (op_i == 3'd0) || (op_i == 3'd1) || (op_i == 3'd5) || (op_i == 3'd6);
  assign uns_op = (op_i == 3'd2) || (op_i == 3'd3);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      psat_lane_core #(.LANE_W(LANE_W), .SHAMT_W(SHAMT_W), .WIDE_W(WIDE_W)) i_core (
        .op_i    (op_i),
        .shamt_i (shamt_i),
        .a_i     (a_i[g*LANE_W +: LANE_W]),
        .b_i     (b_i[g*LANE_W +: LANE_W]),
        .wide_o  (lane_wide[g]),
        .mode_o  (lane_mode[g])
      );

      psat_lane_clamp #(.LANE_W(LANE_W), .WIDE_W(WIDE_W)) i_clamp (
        .wide_i (lane_wide[g]),
        .mode_i (lane_mode[g]),
        .lane_o (lane_val[g])
      );

      assign comb_res[g*LANE_W +: LANE_W] = lane_val[g];

      AST_SIGNED_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (sgn_op && (lane_wide[g] > S_MAX)) |-> (lane_val[g] == {1'b0, {(LANE_W-1){1'b1}}})); // R2
      AST_SIGNED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (sgn_op && (lane_wide[g] < S_MIN)) |-> (lane_val[g] == {1'b1, {(LANE_W-1){1'b0}}})); // R2
      AST_UNSIGNED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (uns_op && lane_wide[g][WIDE_W-1]) |-> (lane_val[g] == '0)); // R3
      AST_UNSIGNED_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (uns_op && (lane_wide[g] > U_MAX)) |-> (lane_val[g] == '1)); // R3
    end
  endgenerate

  psat_out_stage #(.W(DATA_W), .REGISTERED(OUT_REG)) i_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (comb_res),
    .q_o   (result_o)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd7) |-> (comb_res == '0)); // R8

  generate
    if (OUT_REG) begin : g_reg_chk
      AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (result_o == $past(comb_res))); // R9
    end
  endgenerate

endmodule

// File: tb/test_psat_simd_unit.sv
module test_psat_simd_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  shamt_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psat_simd_unit i_psat_simd_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .shamt_i(shamt_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o)
  );

  function automatic int clamp_int(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Behavioural lane model using plain integers.
  function automatic logic [15:0] ref_lane(int op, int sh, logic [15:0] a, logic [15:0] b);
    int sa, sb, ua, ub, r;
    sa = int'($signed(a));
    sb = int'($signed(b));
    ua = int'(a);
    ub = int'(b);
    case (op)
      0: r = clamp_int(sa + sb, -32768, 32767);
      1: r = clamp_int(sa - sb, -32768, 32767);
      2: r = clamp_int(ua + sb, 0, 65535);
      3: r = clamp_int(ua - sb, 0, 65535);
      4: begin r = ua + ub; r = (r / 2) | (r % 2); end
      5: r = clamp_int(sa * (1 << sh) + sb, -32768, 32767);
      6: r = clamp_int((sa >>> sh) + sb, -32768, 32767);
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic logic [63:0] ref_word(int op, int sh, logic [63:0] a, logic [63:0] b);
    logic [63:0] w;
    for (int k = 0; k < 4; k++)
      w[16*k +: 16] = ref_lane(op, sh, a[16*k +: 16], b[16*k +: 16]);
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply operands at a falling edge and sample one clock later, after the register.
  task automatic step(string req, int op, int sh, logic [63:0] a, logic [63:0] b, logic [63:0] exp);
    @(negedge clk);
    op_i = op[2:0]; shamt_i = sh[1:0]; a_i = a; b_i = b;
    @(negedge clk);
    check(req, result_o, exp);
  endtask

  task automatic step_ref(string req, int op, int sh, logic [63:0] a, logic [63:0] b);
    step(req, op, sh, a, b, ref_word(op, sh, a, b));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    op_i = 3'd0; a_i = 64'h7fff_7fff_7fff_7fff; b_i = 64'h0001_0001_0001_0001;
    repeat (3) @(negedge clk);
    check("R9 reset clears result", result_o, 64'h0);
    rst_n = 1'b1;

    step("R2 R1 signed add clamp", 0, 0, 64'h0000_1234_8000_7fff, 64'h0000_0001_ffff_0001, 64'h0000_1235_8000_7fff);
    step("R2 signed sub clamp", 1, 0, 64'h0000_0005_7fff_8000, 64'h0003_0009_ffff_0001, 64'hfffd_fffc_7fff_8000);
    step("R3 unsigned add clamp", 2, 0, 64'h8000_0000_0001_ffff, 64'h7fff_8000_ffff_0001, 64'hffff_0000_0000_ffff);
    step("R3 unsigned sub clamp", 3, 0, 64'h1234_ffff_1000_0000, 64'h0234_ffff_8000_0001, 64'h1000_ffff_9000_0000);
    step("R4 average or-round", 4, 0, 64'h0003_0002_0001_ffff, 64'h0000_0002_0002_ffff, 64'h0001_0002_0001_ffff);
    step("R5 shift-left add", 5, 3, 64'h0001_c000_ffff_1000, 64'h7ff8_0000_0005_0000, 64'h7fff_8000_fffd_7fff);
    step("R6 shift-right add", 6, 2, 64'h0000_fffd_7fff_8000, 64'h0000_0000_7fff_0000, 64'h0000_ffff_7fff_e000);
    step("R7 shamt ignored by signed add", 0, 3, 64'h0000_1234_8000_7fff, 64'h0000_0001_ffff_0001, 64'h0000_1235_8000_7fff);
    step("R7 shamt ignored by average", 4, 2, 64'h0003_0002_0001_ffff, 64'h0000_0002_0002_ffff, 64'h0001_0002_0001_ffff);
    step("R8 unused opcode zero", 7, 1, 64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0, 64'h0);
    step("R6 shift zero equals add", 6, 0, 64'h4000_c000_0001_ffff, 64'h4000_c000_0002_0001, 64'h7fff_8000_0003_0000);
    step("R5 shift one", 5, 1, 64'h0100_ff00_3fff_c001, 64'h0001_0000_0001_ffff, 64'h0201_fe00_7fff_8001);

    for (int i = 0; i < 400; i++) begin
      step_ref("R1 random lanes", i % 8, int'($urandom_range(0, 3)),
               {$urandom, $urandom}, {$urandom, $urandom});
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset clears", result_o, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R9 after reset", 0, 0, 64'h0001_0002_0003_0004, 64'h0001_0001_0001_0001, 64'h0002_0003_0004_0005);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule